// File: doc/BRIEF.md
# Unified Data-Space Decoder with Core Registers

This block sits between a microcontroller core's load/store unit and the rest of the chip. Each byte access carries one address in a single flat data space. The block sorts the address into one of three regions. Low addresses reach a general register file that the block holds. A middle window reaches I/O ports. Everything above that goes out to data memory.

Eight ports at the top of the I/O window are owned by the core and are held inside the block:

- five extended-address bytes, each kept pre-shifted into bits 23:16 of a 24-bit value;
- the stack pointer, split into a low byte and a high byte;
- a status byte, stored without any flag meaning.

Every other I/O port is forwarded to an external I/O bus. Feature inputs say which optional registers exist on a given part. A write to a register that is not present changes nothing.

Reads from the register file and from the core registers answer in the same cycle as the request. Reads from the external I/O bus and from memory answer one cycle later, marked by the response strobe.

Top module: `data_space_decoder`

## Requirements
- R1: An address below 0x20 selects the register file and asserts neither `io_sel` nor `mem_sel`. An address from 0x20 to 0x5F is I/O port (address − 0x20). An address of 0x60 or more asserts `mem_sel` with `mem_addr` equal to the address. At most one of `io_sel` and `mem_sel` is high at a time.
- R2: A write to register index n (address n, n < 32) is readable at the same address from the next cycle onward. Other registers keep their contents.
- R3: A write to port 0x38, 0x39, 0x3A, 0x3B or 0x3C (data addresses 0x58 to 0x5C) stores the byte into bits 23:16 of the matching 24-bit output, with bits 15:0 zero. The port-to-output order is `core_rampd`, `core_rampx`, `core_rampy`, `core_rampz`, `core_eind`. A read of that port returns bits 23:16.
- R4: Writes to ports 0x38 to 0x3B change their register only while the matching feature input (`feat_rampd`, `feat_rampx`, `feat_rampy`, `feat_rampz`) is high. Port 0x3C is always writable.
- R5: A write to port 0x3D (address 0x5D) replaces `core_sp[7:0]` and keeps `core_sp[15:8]`. A read of that port returns `core_sp[7:0]`.
- R6: A write to port 0x3E (address 0x5E) replaces `core_sp[15:8]` only while `feat_sp16` is high. A read of that port returns `core_sp[15:8]`.
- R7: Port 0x3F (address 0x5F) is a plain status byte that is written and read back unchanged.
- R8: Ports 0x38 to 0x3F never appear on the external I/O bus: `io_sel` stays low for them.
- R9: Only bits 7:0 of `req_wdata` are stored or forwarded. Bits 15:8 have no effect.
- R10: A read of the register file or of a core register drives `rsp_valid` and `rsp_data` in the same cycle. A read of the external I/O bus or of memory drives `rsp_valid` one cycle later, carrying `io_rdata` or `mem_rdata` from that cycle.
- R11: After reset, every core register and general register is zero, `core_sp` equals `SP_RESET`, and `rsp_valid` is low.
- R12: A write request, or an idle cycle, produces no response unless an external read from the previous cycle is returning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_rampd | input | 1 | Extended data-address byte present |
| feat_rampx | input | 1 | Extended X-pointer byte present |
| feat_rampy | input | 1 | Extended Y-pointer byte present |
| feat_rampz | input | 1 | Extended Z-pointer byte present |
| feat_sp16 | input | 1 | Stack pointer high byte present |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data-space byte address |
| req_wdata | input | 16 | Write data (low byte used) |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data |
| io_sel | output | 1 | External I/O port access |
| io_we | output | 1 | External I/O write |
| io_port | output | 6 | External I/O port number |
| io_wdata | output | 8 | External I/O write byte |
| io_rdata | input | 8 | External I/O read byte, one cycle after request |
| mem_sel | output | 1 | Data memory access |
| mem_we | output | 1 | Data memory write |
| mem_addr | output | 16 | Data memory address |
| mem_wdata | output | 8 | Data memory write byte |
| mem_rdata | input | 8 | Data memory read byte, one cycle after request |
| core_rampd | output | 24 | Extended data-address value |
| core_rampx | output | 24 | Extended X-pointer value |
| core_rampy | output | 24 | Extended Y-pointer value |
| core_rampz | output | 24 | Extended Z-pointer value |
| core_eind | output | 24 | Extended indirect-jump value |
| core_sp | output | 16 | Stack pointer |
| core_sreg | output | 8 | Status byte |

## Verification
A read that hits the register file or a core register is due in the cycle the request is driven. A read that goes to the I/O bus or memory is due in the following cycle. Register state and the `core_*` outputs change at the rising edge that ends a write cycle.

The bench drives each request on a falling edge and then leaves one idle cycle, so no two responses can overlap. When it issues a read, the driver queues the expected byte. A monitor samples one nanosecond before every rising edge, pops the queue on `rsp_valid`, and treats an unexpected strobe or an unanswered entry as an error. Bus outputs are checked inside the request cycle, and state outputs are checked inside the idle cycle that follows.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [1:0] {
    TGT_GPR  = 2'd0,
    TGT_CORE = 2'd1,
    TGT_XIO  = 2'd2,
    TGT_MEM  = 2'd3
  } tgt_e;

  // Offset of each core register from the first core-owned port.
  // A neighbouring decoder relies on this order.
  typedef enum logic [2:0] {
    CR_XD   = 3'd0,
    CR_XX   = 3'd1,
    CR_XY   = 3'd2,
    CR_XZ   = 3'd3,
    CR_XI   = 3'd4,
    CR_SPLO = 3'd5,
    CR_SPHI = 3'd6,
    CR_STAT = 3'd7
  } core_e;

  localparam int unsigned CORE_PORT_BASE = 'h38;
  localparam int unsigned N_XBYTES       = 5;
endpackage

// File: rtl/dsd_addr_decode.sv
module dsd_addr_decode
  import dsd_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned NREG = 32,
  parameter int unsigned NIO  = 64
) (
  input  logic [AW-1:0]           addr,
  output tgt_e                    tgt,
  output logic [$clog2(NREG)-1:0] reg_idx,
  output logic [$clog2(NIO)-1:0]  port,
  output core_e                   core_sel
);
  localparam int unsigned RW = $clog2(NREG);
  localparam int unsigned PW = $clog2(NIO);
  localparam logic [AW-1:0] IO_LO = AW'(NREG);
  localparam logic [AW-1:0] IO_HI = AW'(NREG + NIO);
  localparam logic [PW-1:0] CBASE = PW'(CORE_PORT_BASE);

  logic [AW-1:0] io_off;

  always_comb begin
    io_off   = addr - IO_LO;
    reg_idx  = addr[RW-1:0];
    port     = io_off[PW-1:0];
    core_sel = core_e'(port[2:0]);
    if (addr < IO_LO) begin
      tgt = TGT_GPR;
    end else if (addr < IO_HI) begin
      tgt = (port >= CBASE) ? TGT_CORE : TGT_XIO;
    end else begin
      tgt = TGT_MEM;
    end
  end
endmodule

// File: rtl/dsd_regfile.sv
module dsd_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] idx,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata
);
  logic [DW-1:0] gpr_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_gpr
    logic          ld;
    logic [DW-1:0] gpr_d;

    always_comb begin
      ld    = wr_en && (idx == i[$clog2(NREG)-1:0]);
      gpr_d = ld ? wdata : gpr_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gpr_q[i] <= '0;
      end else begin
        gpr_q[i] <= gpr_d;
      end
    end
  end

  assign rdata = gpr_q[idx];
endmodule

// File: rtl/dsd_core_regs.sv
module dsd_core_regs
  import dsd_pkg::*;
#(
  parameter int unsigned  DW       = 8,
  parameter int unsigned  XW       = 24,
  parameter int unsigned  SPW      = 16,
  parameter logic [15:0]  SP_RESET = 16'h08FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  core_e              sel,
  input  logic [DW-1:0]      wdata,
  input  logic [N_XBYTES-2:0] feat_x,
  input  logic               feat_sp16,
  output logic [DW-1:0]      rdata,
  output logic [XW-1:0]      xval [N_XBYTES],
  output logic [SPW-1:0]     sp,
  output logic [DW-1:0]      sreg
);
  localparam int unsigned XLSB = XW - DW;

  logic [N_XBYTES-1:0] xgate;
  logic [XW-1:0]       x_q [N_XBYTES];
  logic [SPW-1:0]      sp_q, sp_d;
  logic [DW-1:0]       sr_q, sr_d;

  // The last extended byte has no feature input and is always writable.
  assign xgate = {1'b1, feat_x};

  for (genvar i = 0; i < N_XBYTES; i++) begin : g_xbyte
    logic          ld;
    logic [XW-1:0] x_d;

    always_comb begin
      ld  = wr_en && xgate[i] && (sel == core_e'(i));
      x_d = ld ? {wdata, {XLSB{1'b0}}} : x_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x_q[i] <= '0;
      end else begin
        x_q[i] <= x_d;
      end
    end

    assign xval[i] = x_q[i];
  end

  always_comb begin
    sp_d = sp_q;
    sr_d = sr_q;
    if (wr_en) begin
      unique case (sel)
        CR_SPLO: sp_d[DW-1:0] = wdata;
        CR_SPHI: if (feat_sp16) sp_d[SPW-1:DW] = wdata;
        CR_STAT: sr_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= SP_RESET;
      sr_q <= '0;
    end else begin
      sp_q <= sp_d;
      sr_q <= sr_d;
    end
  end

  always_comb begin
    unique case (sel)
      CR_SPLO: rdata = sp_q[DW-1:0];
      CR_SPHI: rdata = sp_q[SPW-1:DW];
      CR_STAT: rdata = sr_q;
      default: rdata = x_q[sel][XW-1:XLSB];
    endcase
  end

  assign sp   = sp_q;
  assign sreg = sr_q;
endmodule

// File: rtl/data_space_decoder.sv
module data_space_decoder
  import dsd_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned WIN      = 16,
  parameter int unsigned NREG     = 32,
  parameter int unsigned NIO      = 64,
  parameter logic [15:0] SP_RESET = 16'h08FF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   feat_rampd,
  input  logic                   feat_rampx,
  input  logic                   feat_rampy,
  input  logic                   feat_rampz,
  input  logic                   feat_sp16,
  input  logic                   req_valid,
  input  logic                   req_we,
  input  logic [AW-1:0]          req_addr,
  input  logic [WIN-1:0]         req_wdata,
  output logic                   rsp_valid,
  output logic [7:0]             rsp_data,
  output logic                   io_sel,
  output logic                   io_we,
  output logic [$clog2(NIO)-1:0] io_port,
  output logic [7:0]             io_wdata,
  input  logic [7:0]             io_rdata,
  output logic                   mem_sel,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [7:0]             mem_wdata,
  input  logic [7:0]             mem_rdata,
  output logic [23:0]            core_rampd,
  output logic [23:0]            core_rampx,
  output logic [23:0]            core_rampy,
  output logic [23:0]            core_rampz,
  output logic [23:0]            core_eind,
  output logic [15:0]            core_sp,
  output logic [7:0]             core_sreg
);
  localparam int unsigned DW = 8;
  localparam int unsigned RW = $clog2(NREG);
  localparam int unsigned PW = $clog2(NIO);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic [DW-1:0]  wbyte;
  logic [WIN-1:0] unused_wdata;
  assign wbyte        = req_wdata[DW-1:0];
  assign unused_wdata = req_wdata;

  tgt_e          tgt;
  logic [RW-1:0] reg_idx;
  logic [PW-1:0] port;
  core_e         core_sel;

  dsd_addr_decode #(.AW(AW), .NREG(NREG), .NIO(NIO)) u_dec (
    .addr     (req_addr),
    .tgt      (tgt),
    .reg_idx  (reg_idx),
    .port     (port),
    .core_sel (core_sel)
  );

  logic          gpr_we, core_we;
  logic [DW-1:0] gpr_rd, core_rd;

  assign gpr_we  = req_valid && req_we && (tgt == TGT_GPR);
  assign core_we = req_valid && req_we && (tgt == TGT_CORE);

  dsd_regfile #(.NREG(NREG), .DW(DW)) u_gpr (
    .clk   (clk),
    .rst_n (rst_s_q),
    .wr_en (gpr_we),
    .idx   (reg_idx),
    .wdata (wbyte),
    .rdata (gpr_rd)
  );

  logic [23:0] xval [N_XBYTES];

  dsd_core_regs #(.DW(DW), .XW(24), .SPW(16), .SP_RESET(SP_RESET)) u_core (
    .clk       (clk),
    .rst_n     (rst_s_q),
    .wr_en     (core_we),
    .sel       (core_sel),
    .wdata     (wbyte),
    .feat_x    ({feat_rampz, feat_rampy, feat_rampx, feat_rampd}),
    .feat_sp16 (feat_sp16),
    .rdata     (core_rd),
    .xval      (xval),
    .sp        (core_sp),
    .sreg      (core_sreg)
  );

  assign core_rampd = xval[CR_XD];
  assign core_rampx = xval[CR_XX];
  assign core_rampy = xval[CR_XY];
  assign core_rampz = xval[CR_XZ];
  assign core_eind  = xval[CR_XI];

  // External buses
  always_comb begin
    io_sel    = req_valid && (tgt == TGT_XIO);
    io_we     = io_sel && req_we;
    io_port   = port;
    io_wdata  = wbyte;
    mem_sel   = req_valid && (tgt == TGT_MEM);
    mem_we    = mem_sel && req_we;
    mem_addr  = req_addr;
    mem_wdata = wbyte;
  end

  // One-cycle return tracking for external reads
  logic pend_q, pend_d, pmem_q, pmem_d;
  logic int_rd;

  always_comb begin
    int_rd = req_valid && !req_we && ((tgt == TGT_GPR) || (tgt == TGT_CORE));
    pend_d = (io_sel || mem_sel) && !req_we;
    pmem_d = mem_sel;
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      pend_q <= 1'b0;
      pmem_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      pmem_q <= pmem_d;
    end
  end

  // A returning external read takes the response port.
  always_comb begin
    rsp_valid = pend_q || int_rd;
    if (pend_q) begin
      rsp_data = pmem_q ? mem_rdata : io_rdata;
    end else if (int_rd) begin
      rsp_data = (tgt == TGT_GPR) ? gpr_rd : core_rd;
    end else begin
      rsp_data = '0;
    end
  end
endmodule

// File: rtl/data_space_decoder_chk.sv
module data_space_decoder_chk (
  input logic        clk,
  input logic        rst_sn,
  input logic        req_valid,
  input logic        req_we,
  input logic        io_sel,
  input logic        mem_sel,
  input logic [5:0]  io_port,
  input logic        rsp_valid,
  input logic        feat_rampd,
  input logic [23:0] core_rampd,
  input logic        feat_sp16,
  input logic [15:0] core_sp
);
  p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    !(io_sel && mem_sel));

  p_core_hidden_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    io_sel |-> (io_port < 6'h38));

  p_rampd_gate_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    !feat_rampd |=> $stable(core_rampd));

  p_sph_gate_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    !feat_sp16 |=> (core_sp[15:8] == $past(core_sp[15:8])));

  p_ext_latency_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && !req_we && (io_sel || mem_sel)) |=> rsp_valid);
endmodule

bind data_space_decoder data_space_decoder_chk u_chk (
  .clk        (clk),
  .rst_sn     (rst_s_q),
  .req_valid  (req_valid),
  .req_we     (req_we),
  .io_sel     (io_sel),
  .mem_sel    (mem_sel),
  .io_port    (io_port),
  .rsp_valid  (rsp_valid),
  .feat_rampd (feat_rampd),
  .core_rampd (core_rampd),
  .feat_sp16  (feat_sp16),
  .core_sp    (core_sp)
);

// File: tb/tb_data_space_decoder.sv
`timescale 1ns/1ps
module tb_data_space_decoder;
  localparam logic [15:0] SPR = 16'h08FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic feat_rampd = 0, feat_rampx = 0, feat_rampy = 0, feat_rampz = 0, feat_sp16 = 0;
  logic req_valid = 0, req_we = 0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic rsp_valid;
  logic [7:0] rsp_data;
  logic io_sel, io_we, mem_sel, mem_we;
  logic [5:0] io_port;
  logic [7:0] io_wdata, mem_wdata;
  logic [7:0] io_rdata = '0, mem_rdata = '0;
  logic [15:0] mem_addr, core_sp;
  logic [23:0] core_rampd, core_rampx, core_rampy, core_rampz, core_eind;
  logic [7:0] core_sreg;

  always #4 clk = ~clk;

  data_space_decoder #(.SP_RESET(SPR)) dut (.*);

  // External I/O and memory models: answer one cycle after a read.
  always @(posedge clk) begin
    if (io_sel && !io_we) io_rdata <= {2'b00, io_port} ^ 8'hC3;
    if (mem_sel && !mem_we) mem_rdata <= mem_addr[7:0] ^ mem_addr[15:8] ^ 8'h5A;
  end

  int n_vec = 0, n_bad = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: one ns before each rising edge.
  always @(negedge clk) begin
    #3;
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R12 unexpected response", 32'(rsp_data), 32'hFFFF_FFFF);
      end else begin
        chk(tag_q.pop_front(), 32'(rsp_data), 32'(exp_q.pop_front()));
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    req_valid = 0; req_we = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = a; req_wdata = d;
    #2;
    chk("R12 no response on write", 32'(rsp_valid), 0);
    idle();
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    req_valid = 1; req_we = 0; req_addr = a;
    idle();
  endtask

  initial begin
    #(8 * 200000);
    chk("watchdog", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #21 rst_n = 1;
    repeat (4) @(negedge clk);
    #2;
    // R11 reset state
    chk("R11 sp reset", 32'(core_sp), 32'(SPR));
    chk("R11 rampd reset", 32'(core_rampd), 0);
    chk("R11 eind reset", 32'(core_eind), 0);
    chk("R11 sreg reset", 32'(core_sreg), 0);
    chk("R11 no response", 32'(rsp_valid), 0);
    rd(16'h0003, 8'h00, "R11 gpr reset");

    // R2 / R9 register file
    wr(16'h0005, 16'h71A7);
    rd(16'h0005, 8'hA7, "R2 R9 gpr write low byte");
    wr(16'h001F, 16'h003C);
    rd(16'h001F, 8'h3C, "R2 gpr 31");
    rd(16'h0004, 8'h00, "R2 neighbour untouched");

    // R1 / R9 decode at the bus
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = 16'h0020; req_wdata = 16'hBE55;
    #2;
    chk("R1 io_sel at 0x20", 32'(io_sel), 1);
    chk("R1 port 0", 32'(io_port), 0);
    chk("R9 io_wdata low byte", 32'(io_wdata), 32'h55);
    chk("R1 mem_sel low for io", 32'(mem_sel), 0);
    req_addr = 16'h0057;
    #1;
    chk("R1 port 0x37 forwarded", {31'b0, io_sel}, 1);
    chk("R1 port 0x37 number", 32'(io_port), 32'h37);
    req_addr = 16'h0060;
    #1;
    chk("R1 mem_sel at 0x60", 32'(mem_sel), 1);
    chk("R1 mem_addr", 32'(mem_addr), 32'h60);
    chk("R9 mem_wdata low byte", 32'(mem_wdata), 32'h55);
    req_addr = 16'h001F;
    #1;
    chk("R1 gpr no bus", 32'({io_sel, mem_sel}), 0);
    req_addr = 16'h001F; req_wdata = 16'h003C;
    idle();

    // R10 external read latency
    rd(16'h0021, 8'h01 ^ 8'hC3, "R10 io read");
    rd(16'h1234, 8'h34 ^ 8'h12 ^ 8'h5A, "R10 mem read");

    // R3 / R4 extended bytes
    feat_rampd = 1; feat_rampy = 1;
    wr(16'h0058, 16'h119C);
    #2;
    chk("R3 rampd pre-shifted", 32'(core_rampd), 32'h9C0000);
    rd(16'h0058, 8'h9C, "R3 rampd read");
    wr(16'h0059, 16'h0077);
    #2;
    chk("R4 rampx gated off", 32'(core_rampx), 0);
    rd(16'h0059, 8'h00, "R4 rampx read gated");
    wr(16'h005A, 16'h00E1);
    #2;
    chk("R3 rampy", 32'(core_rampy), 32'hE10000);
    wr(16'h005B, 16'h0012);
    #2;
    chk("R4 rampz gated off", 32'(core_rampz), 0);
    wr(16'h005C, 16'h00D4);
    #2;
    chk("R4 eind always writable", 32'(core_eind), 32'hD40000);
    rd(16'h005C, 8'hD4, "R3 eind read");
    feat_rampd = 0;
    wr(16'h0058, 16'h0001);
    #2;
    chk("R4 rampd gated after disable", 32'(core_rampd), 32'h9C0000);

    // R5 / R6 stack pointer
    wr(16'h005D, 16'h0042);
    #2;
    chk("R5 spl write", 32'(core_sp), 32'h0842);
    wr(16'h005E, 16'h0011);
    #2;
    chk("R6 sph ignored 8-bit sp", 32'(core_sp), 32'h0842);
    rd(16'h005E, 8'h08, "R6 sph read");
    feat_sp16 = 1;
    wr(16'h005E, 16'h0011);
    #2;
    chk("R6 sph write", 32'(core_sp), 32'h1142);
    rd(16'h005D, 8'h42, "R5 spl read");

    // R7 / R8 status byte, core port hidden from bus
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = 16'h005F; req_wdata = 16'h00B5;
    #2;
    chk("R8 core port not forwarded", 32'({io_sel, mem_sel}), 0);
    idle();
    #2;
    chk("R7 sreg stored", 32'(core_sreg), 32'hB5);
    rd(16'h005F, 8'hB5, "R7 sreg read");

    repeat (3) @(negedge clk);
    chk("R10 all responses seen", 32'(exp_q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule